// File: doc/BRIEF.md
# SPI Memory Access Bridge

This block is an SPI target that lets an external host read and write a 64K-byte memory on the local side. It also passes command bytes to a local processor through a command register and an interrupt pulse. The SPI pins are oversampled in the system clock domain through a short synchronizer. Bits are sampled on SCK rising edges and shifted out on SCK falling edges, MSB first (SPI mode 0).

A transaction of exactly one byte is a pure command. A longer transaction carries, in order, a high address byte, a low address byte, a command byte, a status byte and then data bytes. While the status byte is clocked in, the target returns the status of the previous transaction on MISO. For reads, the memory is fetched one byte ahead so that data follows the status byte with no gap. A safe-mode input restricts host writes to a 16-byte window.

Top module: `spi_mem_bridge`

## Requirements
- R1: After reset the command register and status register are 0x00, the interrupt is low, MISO is low, and neither memory strobe is active.
- R2: A transaction of exactly one complete byte loads that byte into the command register and raises the interrupt, for every value including 0x00 and 0x80.
- R3: In a transaction of three or more bytes, the bytes are taken in this order: address high, address low, command, status, then data. A command MSB of 0 selects write. Each complete write data byte is stored at the header address, and the address then advances by one per byte.
- R4: When chip-select rises after a transaction of three or more bytes, the command byte is loaded into the command register and the interrupt is raised, unless the command is 0x00 or 0x80. For those two values the register keeps its value and no interrupt occurs. The register is never cleared by deselection.
- R5: MISO carries 0 during the first three bytes and during write data bytes. A command MSB of 1 selects read. In a read, each data byte carries the memory contents starting at the header address and incrementing by one per byte.
- R6: The status byte has bit 0 set to the XOR of every bit received in the previous transaction (trailing partial bits included), bit 1 set to that transaction's error flag, and bits 7:2 zero. This byte is sent on MISO during the fourth byte and appears on the status output after chip-select rises.
- R7: A transaction whose bit count is not a multiple of 8 sets the error flag. Its completed bytes are still processed.
- R8: If the ready input is low when any byte completes, the error flag is set. A write byte that completes while ready is low is dropped.
- R9: With safe mode on, writes take effect only at addresses 0x400 to 0x40F inclusive. Other writes are dropped, but the address still advances.
- R10: A transaction of exactly two bytes sets the error flag, makes no memory access, raises no interrupt and leaves the command register unchanged.
- R11: The interrupt lasts one clock cycle. Every memory strobe follows a byte completion, and read and write are never strobed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_sck | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data expected one cycle later |
| mem_rdata | input | 8 | Memory read data |
| host_cmd | output | 8 | Command register for the local processor |
| host_irq | output | 1 | One-cycle command interrupt |
| host_stat | output | 8 | Status of the last finished transaction |
| dev_ready | input | 1 | Local side ready; low flags an error |
| safe_en | input | 1 | Restrict writes to the safe window |

## Verification
Several properties are checked on every cycle:
- the interrupt is a single-cycle pulse that follows only the end of a transaction;
- the command register changes at no other moment;
- every write strobe lands inside the window while safe mode is on, and only while ready was high;
- a two-byte transaction never interrupts;
- memory strobes are exclusive and tied to byte completions.

The remaining behaviour can only be shown by the bench's scenarios. This covers whether the right byte reaches the command register, the parity and error bits reported one transaction later, the read data and its address sequence on MISO, and the memory image after writes that cross the safe-window edges.

// File: rtl/spib_pkg.sv
package spib_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Commands whose low seven bits are zero do not notify the processor.
  function automatic logic f_cmd_quiet(input byte_t c);
    return c[6:0] == 7'd0;
  endfunction

  function automatic logic f_in_window(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
    return (a >= base) && (a < base + size);
  endfunction

  function automatic byte_t f_status(input logic err, input logic par);
    return {6'd0, err, par};
  endfunction
endpackage

// File: rtl/spib_sync.sv
module spib_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic mosi_s
);
  // bit 2: chip-select, bit 1: sck, bit 0: mosi
  logic [2:0] pipe [STAGES];
  logic [2:0] last;
  logic [2:0] cur;

  assign cur = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b100;
      last <= 3'b100;
    end else begin
      pipe[0] <= {cs_n_i, sck_i, mosi_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      last <= cur;
    end
  end

  assign sck_rise = !cur[2] && cur[1] && !last[1];
  assign sck_fall = !cur[2] && !cur[1] && last[1];
  assign cs_fall  = !cur[2] && last[2];
  assign cs_rise  = cur[2] && !last[2];
  assign mosi_s   = cur[0];
endmodule

// File: rtl/spib_rx.sv
module spib_rx import spib_pkg::*; #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             bit_in,
  output logic             byte_done,
  output byte_t            rx_byte,
  output logic [CNT_W-1:0] n_bytes,
  output logic [2:0]       bit_pos,
  output logic             par
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  byte_t sr;

  assign byte_done = shift && (bit_pos == 3'd7);
  assign rx_byte   = {sr[6:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; bit_pos <= '0; n_bytes <= '0; par <= 1'b0;
    end else if (clear) begin
      sr <= '0; bit_pos <= '0; n_bytes <= '0; par <= 1'b0;
    end else if (shift) begin
      sr      <= rx_byte;
      par     <= par ^ bit_in;
      bit_pos <= bit_pos + 3'd1;
      if (byte_done && n_bytes != CNT_MAX) n_bytes <= n_bytes + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spib_tx.sv
module spib_tx import spib_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  load,
  input  byte_t load_val,
  input  logic  shift,
  output logic  miso
);
  byte_t sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (clear) sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[6:0], 1'b0};
  end

  assign miso = sr[BYTE_W-1];
endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge import spib_pkg::*; #(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       CNT_W       = 6,
  parameter logic [ADDR_W-1:0] SAFE_BASE   = 16'h0400,
  parameter int unsigned       SAFE_SIZE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        host_cmd,
  output logic              host_irq,
  output logic [7:0]        host_stat,
  input  logic              dev_ready,
  input  logic              safe_en
);
  localparam logic [CNT_W-1:0] IDX_HI   = CNT_W'(0);
  localparam logic [CNT_W-1:0] IDX_LO   = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_CMD  = CNT_W'(2);
  localparam logic [CNT_W-1:0] IDX_STAT = CNT_W'(3);
  localparam logic [CNT_W-1:0] IDX_DATA = CNT_W'(4);

  logic sck_rise, sck_fall, cs_fall, cs_rise, mosi_s;
  logic byte_done, rx_par;
  byte_t rx_byte;
  logic [CNT_W-1:0] n_bytes;
  logic [2:0] bit_pos;

  byte_t hdr_hi, hdr_lo, cmd_q, status_q, pref_q, cmd_reg, tx_val;
  logic is_rd, rdy_err, rd_pend, irq_q;
  logic [ADDR_W-1:0] ptr_q, hdr_addr;

  // named events, observed by the bound checker
  logic end_evt, wr_fire, rd_fire, win_ok, cmd_take, frame_err, short_err;
  logic tx_load, tx_shift;

  spib_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .mosi_s(mosi_s)
  );

  spib_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(cs_fall), .shift(sck_rise), .bit_in(mosi_s),
    .byte_done(byte_done), .rx_byte(rx_byte), .n_bytes(n_bytes), .bit_pos(bit_pos),
    .par(rx_par)
  );

  spib_tx u_tx (
    .clk(clk), .rst_n(rst_n), .clear(cs_fall), .load(tx_load), .load_val(tx_val),
    .shift(tx_shift), .miso(spi_miso)
  );

  assign hdr_addr  = {hdr_hi, hdr_lo};
  assign end_evt   = cs_rise;
  assign frame_err = (bit_pos != 3'd0);
  assign short_err = (n_bytes == IDX_CMD);
  assign win_ok    = !safe_en || f_in_window(32'(ptr_q), 32'(SAFE_BASE), 32'(SAFE_SIZE));
  assign wr_fire   = byte_done && !is_rd && (n_bytes >= IDX_DATA) && dev_ready && win_ok;
  assign rd_fire   = byte_done && (((n_bytes == IDX_CMD) && rx_byte[7]) ||
                                   ((n_bytes >= IDX_STAT) && is_rd));
  assign cmd_take  = end_evt && ((n_bytes == IDX_LO) ||
                                 ((n_bytes > IDX_CMD) && !f_cmd_quiet(cmd_q)));

  // The status byte is loaded when the command byte completes; after that
  // each byte boundary loads prefetched data (read) or zero (write).
  assign tx_load  = byte_done && (n_bytes >= IDX_CMD);
  assign tx_val   = (n_bytes == IDX_CMD) ? status_q : (is_rd ? pref_q : '0);
  assign tx_shift = sck_fall && (bit_pos != 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_hi <= '0; hdr_lo <= '0; cmd_q <= '0; status_q <= '0; pref_q <= '0;
      cmd_reg <= '0; is_rd <= 1'b0; rdy_err <= 1'b0; rd_pend <= 1'b0; irq_q <= 1'b0;
      ptr_q <= '0; mem_addr <= '0; mem_wdata <= '0; mem_we <= 1'b0; mem_re <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
      irq_q   <= 1'b0;
      rd_pend <= mem_re;
      if (rd_pend) pref_q <= mem_rdata;

      if (cs_fall) begin
        is_rd   <= 1'b0;
        rdy_err <= 1'b0;
      end

      if (byte_done) begin
        if (!dev_ready) rdy_err <= 1'b1;
        if (n_bytes == IDX_HI) hdr_hi <= rx_byte;
        if (n_bytes == IDX_LO) hdr_lo <= rx_byte;
        if (n_bytes == IDX_CMD) begin
          cmd_q <= rx_byte;
          is_rd <= rx_byte[7];
          ptr_q <= rx_byte[7] ? hdr_addr + ADDR_W'(1) : hdr_addr;
        end
        if (n_bytes >= IDX_STAT && is_rd)  ptr_q <= ptr_q + ADDR_W'(1);
        if (n_bytes >= IDX_DATA && !is_rd) ptr_q <= ptr_q + ADDR_W'(1);
        if (rd_fire) begin
          mem_re   <= 1'b1;
          mem_addr <= (n_bytes == IDX_CMD) ? hdr_addr : ptr_q;
        end
        if (wr_fire) begin
          mem_we    <= 1'b1;
          mem_addr  <= ptr_q;
          mem_wdata <= rx_byte;
        end
      end

      if (end_evt) begin
        status_q <= f_status(frame_err || rdy_err || short_err, rx_par);
        if (cmd_take) begin
          cmd_reg <= (n_bytes == IDX_LO) ? hdr_hi : cmd_q;
          irq_q   <= 1'b1;
        end
      end
    end
  end

  assign host_cmd  = cmd_reg;
  assign host_irq  = irq_q;
  assign host_stat = status_q;
endmodule

// File: rtl/spib_checker.sv
module spib_checker import spib_pkg::*; #(
  parameter int unsigned       CNT_W     = 6,
  parameter logic [ADDR_W-1:0] SAFE_BASE = 16'h0400,
  parameter int unsigned       SAFE_SIZE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_irq,
  input logic [7:0]        host_cmd,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              safe_en,
  input logic              dev_ready,
  input logic              end_evt,
  input logic              byte_done,
  input logic [CNT_W-1:0]  n_bytes
);
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);

  p_irq_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(end_evt));

  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !end_evt |=> $stable(host_cmd));

  p_safe_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(safe_en)) |->
      f_in_window(32'(mem_addr), 32'(SAFE_BASE), 32'(SAFE_SIZE)));

  p_write_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(dev_ready));

  p_two_byte_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && n_bytes == CNT_W'(2)) |=> !host_irq);

  p_access_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_access_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> $past(byte_done));
endmodule

bind spi_mem_bridge spib_checker #(
  .CNT_W(CNT_W), .SAFE_BASE(SAFE_BASE), .SAFE_SIZE(SAFE_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_irq(host_irq), .host_cmd(host_cmd),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .safe_en(safe_en),
  .dev_ready(dev_ready), .end_evt(end_evt), .byte_done(byte_done), .n_bytes(n_bytes)
);

// File: tb/tb_spi_mem_bridge.sv
module tb_spi_mem_bridge;
  import spib_pkg::*;
  localparam int HALF  = 6;
  localparam int MEM_N = 2048;
  localparam int BUF_N = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, miso;
  logic [15:0] mem_addr;
  byte_t mem_wdata, mem_rdata, host_cmd, host_stat;
  logic mem_we, mem_re, host_irq;
  logic dev_ready = 1'b1, safe_en = 1'b0;

  byte_t mem [MEM_N];
  byte_t exp_mem [MEM_N];
  byte_t tx_b [BUF_N];
  byte_t rx_b [BUF_N];
  int n_chk = 0, n_bad = 0, irq_total = 0;
  bit done = 0;
  byte_t exp_cmd = 8'h00, exp_stat = 8'h00;

  function automatic byte_t f_seed(input int i);
    return byte_t'(i * 37 + 5);
  endfunction

  function automatic bit f_safe_ok(input int a);
    return (a >= 'h400) && (a <= 'h40F);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= f_seed(i);
    end else begin
      if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[10:0]];
      if (host_irq) irq_total <= irq_total + 1;
    end
  end

  spi_mem_bridge dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .host_cmd(host_cmd), .host_irq(host_irq),
    .host_stat(host_stat), .dev_ready(dev_ready), .safe_en(safe_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic spi_run(input int nbytes, input int extra);
    int total = nbytes * 8 + extra;
    for (int i = 0; i < BUF_N; i++) rx_b[i] = 8'h00;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < total; k++) begin
      mosi = tx_b[k/8][7-(k%8)];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      rx_b[k/8][7-(k%8)] = miso;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic txn(input int nbytes, input int extra);
    int irq0 = irq_total;
    byte_t old_stat = exp_stat;
    int total = nbytes * 8 + extra;
    int par = 0, base, a, bad_at = -1;
    bit err, fire = 0, rd;
    string tag;
    for (int k = 0; k < total; k++) par = par ^ int'(tx_b[k/8][7-(k%8)]);
    base = {16'h0, tx_b[0], tx_b[1]};
    rd = tx_b[2][7];
    spi_run(nbytes, extra);

    err = (extra != 0) || (nbytes == 2) || (!dev_ready && nbytes > 0);
    exp_stat = {6'd0, err, par[0]};
    if (nbytes == 1) begin
      exp_cmd = tx_b[0]; fire = 1;
    end else if (nbytes >= 3 && tx_b[2][6:0] != 7'd0) begin
      exp_cmd = tx_b[2]; fire = 1;
    end
    tag = (nbytes == 1) ? "R2" : (nbytes == 2) ? "R10" : "R4";
    chk((irq_total - irq0) == int'(fire), tag, "irq cycles", irq_total - irq0, int'(fire));
    chk(host_cmd == exp_cmd, tag, "command register", host_cmd, exp_cmd);
    tag = (extra != 0) ? "R7" : (!dev_ready ? "R8" : "R6");
    chk(host_stat == exp_stat, tag, "status output", host_stat, exp_stat);
    if (nbytes >= 3)
      chk((rx_b[0] | rx_b[1] | rx_b[2]) == 8'h00, "R5", "miso in header", rx_b[0] | rx_b[1] | rx_b[2], 0);
    if (nbytes >= 4)
      chk(rx_b[3] == old_stat, "R6", "status byte on miso", rx_b[3], old_stat);
    for (int i = 4; i < nbytes; i++) begin
      a = (base + i - 4) & 'hFFFF;
      if (rd) begin
        chk(rx_b[i] == exp_mem[a % MEM_N], "R5", "read data", rx_b[i], exp_mem[a % MEM_N]);
      end else begin
        chk(rx_b[i] == 8'h00, "R5", "miso during write", rx_b[i], 0);
        if (dev_ready && (!safe_en || f_safe_ok(a))) exp_mem[a % MEM_N] = tx_b[i];
      end
    end
    for (int i = 0; i < MEM_N; i++) if (bad_at < 0 && mem[i] != exp_mem[i]) bad_at = i;
    tag = (nbytes == 2) ? "R10" : safe_en ? "R9" : (!dev_ready ? "R8" : "R3");
    if (bad_at < 0) chk(1'b1, tag, "memory image", 0, 0);
    else chk(1'b0, tag, "memory image", mem[bad_at], exp_mem[bad_at]);
  endtask

  task automatic set_hdr(input int addr, input byte_t cmd);
    tx_b[0] = byte_t'(addr >> 8);
    tx_b[1] = byte_t'(addr);
    tx_b[2] = cmd;
    tx_b[3] = 8'h00;
    for (int i = 4; i < BUF_N; i++) tx_b[i] = byte_t'($urandom);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int nb, ad, ex;
    bit rdm;
    byte_t cm;
    void'($urandom(32'h5eed));
    for (int i = 0; i < MEM_N; i++) exp_mem[i] = f_seed(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(host_cmd == 8'h00, "R1", "cmd after reset", host_cmd, 0);
    chk(host_stat == 8'h00, "R1", "stat after reset", host_stat, 0);
    chk(!host_irq && !miso && !mem_we && !mem_re, "R1", "outputs after reset",
        {host_irq, miso, mem_we, mem_re}, 0);

    // R2 single-byte commands, including the values quiet in longer frames
    tx_b[0] = 8'h80; txn(1, 0);
    tx_b[0] = 8'h00; txn(1, 0);
    tx_b[0] = 8'h5A; txn(1, 0);
    // R3/R4 write with a notifying command
    set_hdr('h0123, 8'h15); txn(8, 0);
    // R5 read back, quiet command 0x80 keeps register (R4)
    set_hdr('h0123, 8'h80); txn(8, 0);
    // R4 quiet write 0x00
    set_hdr('h0200, 8'h00); txn(6, 0);
    // R7 partial trailing byte, then status seen on next frame (R6)
    set_hdr('h0300, 8'h22); txn(5, 3);
    set_hdr('h0300, 8'hA1); txn(6, 0);
    // R10 two-byte frame
    tx_b[0] = 8'h04; tx_b[1] = 8'h00; txn(2, 0);
    // R9 safe window crossing both edges
    safe_en = 1'b1;
    set_hdr('h03FA, 8'h31); txn(32, 0);
    set_hdr('h03F8, 8'h80); txn(32, 0);
    safe_en = 1'b0;
    // R8 not ready
    dev_ready = 1'b0;
    set_hdr('h0500, 8'h41); txn(7, 0);
    dev_ready = 1'b1;
    set_hdr('h0500, 8'h80); txn(7, 0);

    // constrained random frames
    for (int it = 0; it < 40; it++) begin
      safe_en = ($urandom % 3) == 0;
      rdm = $urandom % 2;
      nb = 4 + ($urandom % 20);
      ad = safe_en ? ('h3F0 + ($urandom % 'h30)) : ($urandom % 'h700);
      if (rdm) cm = (($urandom % 4) == 0) ? 8'h80 : (8'h80 | byte_t'($urandom % 128));
      else     cm = (($urandom % 4) == 0) ? 8'h00 : byte_t'($urandom % 128);
      ex = (($urandom % 8) == 0) ? 1 + ($urandom % 7) : 0;
      set_hdr(ad, cm);
      if (($urandom % 10) == 0) nb = 1;
      txn(nb, ex);
    end
    safe_en = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule